// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table from physical memory. The table is never itself translated. A miss arrives as a 32-bit virtual address together with the physical base of the current root table. The walker splits the address into a 10-bit top index, a 10-bit second index and a 12-bit byte offset. It then makes two dependent 32-bit reads over a request/response memory port. The first read fetches a pointer entry from the root table. The second read fetches the leaf entry from the table that the pointer names.

A walk ends in one of two ways. If both entries are present, the walker reports the physical address and the leaf's permission bits, and it emits a refill record for the translation cache, which then goes on to the protection check. If either entry is absent, the walker reports a page fault and names the level that stopped the walk. The walker handles one miss at a time and holds `busy` high for the whole walk.

Entries are 4 bytes and pages are 4 KB. Every entry uses this layout: bit 0 present, bit 1 read allowed, bit 2 write allowed, bit 3 dirty, bit 4 user-accessible, bits 31:12 physical page number.

Top module: `ptw_two_level_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req_valid`, `done_valid` and `refill_valid` are all 0.
- R2: A miss is taken only while `busy` is 0. Once it is taken, `busy` stays 1 through the result cycle and is 0 in the cycle after it. Changes to `miss_valid`, `miss_vaddr` or `root_base` during a walk have no effect on its reads or its result.
- R3: The first read address is `root_base + vaddr[31:22]*4`, using the root value sampled when the miss was taken.
- R4: The second read address is `{pte1[31:12], 12'h000} + vaddr[21:12]*4`, where `pte1` is the first entry read.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R6: At most one read is outstanding. No new request is accepted until the response to the previous one has arrived.
- R7: A first entry with bit 0 clear ends the walk after one read. The result has `done_fault`=1 and `done_level`=0, and `refill_valid` is 0.
- R8: A second entry with bit 0 clear ends the walk with `done_fault`=1 and `done_level`=1, and `refill_valid` is 0.
- R9: A walk that succeeds ends with `done_fault`=0 and `refill_valid`=1. It gives `refill_vpn` = vaddr[31:12], `refill_ppn` = pte2[31:12], `refill_perm` = pte2[4:1] (bit 3 user, 2 dirty, 1 write, 0 read) and `done_paddr` = {pte2[31:12], vaddr[11:0]}.
- R10: `done_valid` is a single-cycle pulse for each walk. `refill_valid` is only ever 1 together with `done_valid` and `done_fault`=0.
- R11: A `mem_rsp_valid` that arrives while no read is outstanding is ignored. It does not start a walk, end one or change a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request; taken when `busy` is 0 |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Physical base of the current root table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle walk result strobe |
| done_fault | output | 1 | The walk ended in a page fault |
| done_level | output | 1 | Level of the last entry read: 0 first, 1 second |
| done_paddr | output | 32 | Translated physical address |
| refill_valid | output | 1 | Refill record for the translation cache is valid |
| refill_vpn | output | 20 | Virtual page number of the walk |
| refill_ppn | output | 20 | Physical page number from the leaf |
| refill_perm | output | 4 | Leaf permissions {user, dirty, write, read} |

## Verification
The bench uses all-ones and all-zeros indices. A walker that sized or shifted its index fields wrongly would read the wrong entry slot or carry into the page number. It holds the ready signal low for several cycles and delays responses. A walker that issued a second read early, or moved its address while stalled, would be caught by the request log. It puts a cleared present bit at each level in turn. A walker that ignored that bit, or mixed up the levels, would issue an extra read, report the wrong level or raise a refill for a fault. It also sends new misses, a changed root and stray responses at moments when they must have no effect. A walker that sampled its inputs again later, or took a response it was not waiting for, would return a wrong address or a phantom result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE,
    ST_FAULT
  } ptw_state_e;

  // Entry layout: presence flag at bit 0, permission nibble right above it
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_PERM_LSB    = 1;
  localparam int PTE_PERM_W      = 4;

  typedef struct packed {
    logic user;
    logic dirty;
    logic wr;
    logic rd;
  } ptw_perm_t;

  localparam logic LVL_ROOT = 1'b0;
  localparam logic LVL_LEAF = 1'b1;

endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic [PA_W-1:0]  pte,
  output logic             present,
  output logic [PPN_W-1:0] ppn,
  output ptw_perm_t        perm
);

  assign present = pte[PTE_PRESENT_BIT];
  assign ppn     = pte[PA_W-1:OFF_W];
  assign perm    = ptw_perm_t'(pte[PTE_PERM_LSB +: PTE_PERM_W]);

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic pte_present,
  output logic busy,
  output logic req_valid,
  output logic sel_leaf,
  output logic take_walk,
  output logic take_root_pte,
  output logic take_leaf_pte,
  output logic done_valid,
  output logic done_fault,
  output logic done_level
);

  ptw_state_e state_q, state_d;
  logic       level_q;

  // Named events so the assertions can watch them
  logic rsp_l1, rsp_l2, miss_l1, miss_l2;

  assign take_walk     = (state_q == ST_IDLE) && miss_valid;
  assign rsp_l1        = (state_q == ST_L1_WAIT) && rsp_valid;
  assign rsp_l2        = (state_q == ST_L2_WAIT) && rsp_valid;
  assign take_root_pte = rsp_l1 && pte_present;
  assign take_leaf_pte = rsp_l2 && pte_present;
  assign miss_l1       = rsp_l1 && !pte_present;
  assign miss_l2       = rsp_l2 && !pte_present;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (miss_valid) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (req_ready) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (miss_l1) state_d = ST_FAULT;
                  else if (take_root_pte) state_d = ST_L2_REQ;
      ST_L2_REQ:  if (req_ready) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (miss_l2) state_d = ST_FAULT;
                  else if (take_leaf_pte) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= LVL_ROOT;
    end else begin
      state_q <= state_d;
      if (rsp_l1)      level_q <= LVL_ROOT;
      else if (rsp_l2) level_q <= LVL_LEAF;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign req_valid  = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign sel_leaf   = (state_q == ST_L2_REQ);
  assign done_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign done_fault = (state_q == ST_FAULT);
  assign done_level = level_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !busy);

  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  assert_root_absent_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_l1 |=> done_valid && done_fault && (done_level == LVL_ROOT));

  assert_leaf_absent_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_l2 |=> done_valid && done_fault && (done_level == LVL_LEAF));

  assert_idle_ignores_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !miss_valid |=> !busy);

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int PPN_W     = PA_W - OFF_W,
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int ENT_SHIFT = $clog2(PA_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_walk,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic [PA_W-1:0]  root_base,
  input  logic             take_root_pte,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             take_leaf_pte,
  input  logic [PPN_W-1:0] leaf_ppn,
  input  ptw_perm_t        leaf_perm,
  input  logic             sel_leaf,
  output logic [PA_W-1:0]  req_addr,
  output logic [VPN_W-1:0] vpn,
  output logic [PPN_W-1:0] ppn_out,
  output ptw_perm_t        perm_out,
  output logic [PA_W-1:0]  paddr
);

  // Slot address inside the first-level table
  function automatic logic [PA_W-1:0] f_root_slot(input logic [PA_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    f_root_slot = base + (PA_W'(idx) << ENT_SHIFT);
  endfunction

  // Slot address inside the second-level table named by a page number
  function automatic logic [PA_W-1:0] f_leaf_slot(input logic [PPN_W-1:0] page,
                                                  input logic [IDX_W-1:0] idx);
    f_leaf_slot = {page, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SHIFT);
  endfunction

  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  root_q;
  logic [PPN_W-1:0] table_ppn_q;
  logic [PPN_W-1:0] leaf_ppn_q;
  ptw_perm_t        leaf_perm_q;

  logic [IDX_W-1:0] idx_top, idx_mid;
  assign idx_top = va_q[VA_W-1 -: IDX_W];
  assign idx_mid = va_q[OFF_W +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q        <= '0;
      root_q      <= '0;
      table_ppn_q <= '0;
      leaf_ppn_q  <= '0;
      leaf_perm_q <= '0;
    end else begin
      if (take_walk) begin
        va_q   <= miss_vaddr;
        root_q <= root_base;
      end
      if (take_root_pte) table_ppn_q <= root_ppn;
      if (take_leaf_pte) begin
        leaf_ppn_q  <= leaf_ppn;
        leaf_perm_q <= leaf_perm;
      end
    end
  end

  assign req_addr = sel_leaf ? f_leaf_slot(table_ppn_q, idx_mid)
                             : f_root_slot(root_q, idx_top);
  assign vpn      = va_q[VA_W-1:OFF_W];
  assign ppn_out  = leaf_ppn_q;
  assign perm_out = leaf_perm_q;
  assign paddr    = {leaf_ppn_q, va_q[OFF_W-1:0]};

  assert_walk_input_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_walk |=> $stable(va_q) && $stable(root_q));

endmodule

// File: rtl/ptw_two_level_walker.sv
module ptw_two_level_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic [PA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             done_valid,
  output logic             done_fault,
  output logic             done_level,
  output logic [PA_W-1:0]  done_paddr,
  output logic             refill_valid,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [PPN_W-1:0] refill_ppn,
  output logic [PTE_PERM_W-1:0] refill_perm
);

  logic             pte_present;
  logic [PPN_W-1:0] pte_ppn;
  ptw_perm_t        pte_perm;
  logic             sel_leaf, take_walk, take_root_pte, take_leaf_pte;
  ptw_perm_t        leaf_perm;

  ptw_pte_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .pte     (mem_rsp_data),
    .present (pte_present),
    .ppn     (pte_ppn),
    .perm    (pte_perm)
  );

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .req_ready     (mem_req_ready),
    .rsp_valid     (mem_rsp_valid),
    .pte_present   (pte_present),
    .busy          (busy),
    .req_valid     (mem_req_valid),
    .sel_leaf      (sel_leaf),
    .take_walk     (take_walk),
    .take_root_pte (take_root_pte),
    .take_leaf_pte (take_leaf_pte),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_level    (done_level)
  );

  ptw_addr #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_walk     (take_walk),
    .miss_vaddr    (miss_vaddr),
    .root_base     (root_base),
    .take_root_pte (take_root_pte),
    .root_ppn      (pte_ppn),
    .take_leaf_pte (take_leaf_pte),
    .leaf_ppn      (pte_ppn),
    .leaf_perm     (pte_perm),
    .sel_leaf      (sel_leaf),
    .req_addr      (mem_req_addr),
    .vpn           (refill_vpn),
    .ppn_out       (refill_ppn),
    .perm_out      (leaf_perm),
    .paddr         (done_paddr)
  );

  assign refill_perm  = leaf_perm;
  assign refill_valid = done_valid && !done_fault;

  assert_req_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

  assert_refill_with_success_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> done_valid && !done_fault);

  assert_vpn_held_in_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_valid |=> $stable(refill_vpn));

  assert_leaf_follows_root_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_root_pte |=> mem_req_valid && sel_leaf);

endmodule

// File: tb/ptw_two_level_walker_tb.sv
module ptw_two_level_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid, done_fault, done_level;
  logic [31:0] done_paddr;
  logic        refill_valid;
  logic [19:0] refill_vpn, refill_ppn;
  logic [3:0]  refill_perm;

  always #2 clk = ~clk;

  ptw_two_level_walker dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .root_base(root_base), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
    .done_paddr(done_paddr), .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_perm(refill_perm)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural memory and its port model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] req_log [0:15];
  int req_cnt = 0, served = 0, overlap = 0, hold_viol = 0, done_cnt = 0;
  int rsp_lat = 0, wcnt = 0, stall_n = 0, stray_n = 0;
  logic        prev_stalled = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    rd = mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (served != req_cnt) overlap <= overlap + 1;
      req_log[req_cnt % 16] <= mem_req_addr;
      req_cnt <= req_cnt + 1;
    end
    if (rst_n && prev_stalled && (!mem_req_valid || mem_req_addr != prev_addr))
      hold_viol <= hold_viol + 1;
    prev_stalled <= rst_n && mem_req_valid && !mem_req_ready;
    prev_addr    <= mem_req_addr;
    if (rst_n && done_valid) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b1;
    if (mem_req_valid && stall_n > 0) begin
      mem_req_ready = 1'b0;
      stall_n--;
    end
    if (stray_n > 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hFFFF_FFFF;
      stray_n--;
    end else if (served != req_cnt) begin
      if (wcnt >= rsp_lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(req_log[served % 16]);
        served++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  // Expected values, written from the requirements
  function automatic logic [31:0] exp_l1(input logic [31:0] va, input logic [31:0] root);
    exp_l1 = root + (32'(va >> 22) * 32'd4);
  endfunction

  function automatic logic [31:0] exp_l2(input logic [31:0] pte1, input logic [31:0] va);
    exp_l2 = (pte1 & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 32'd4);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic map_pages(input logic [31:0] va, input logic [31:0] root,
                           input logic [31:0] pte1, input logic [31:0] pte2);
    mem.delete();
    mem[exp_l1(va, root)] = pte1;
    if (pte1[0]) mem[exp_l2(pte1, va)] = pte2;
  endtask

  logic        r_done, r_fault, r_level, r_refill, a_busy, a_done;
  logic [31:0] r_paddr;
  logic [19:0] r_vpn, r_ppn;
  logic [3:0]  r_perm;

  task automatic run_walk(input logic [31:0] va, input logic [31:0] root, input bit inject);
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va; root_base = root;
    @(negedge clk);
    miss_valid = 1'b0;
    if (inject) begin
      @(negedge clk);
      miss_valid = 1'b1; miss_vaddr = ~va; root_base = root + 32'h1000;
      @(negedge clk);
      @(negedge clk);
      miss_valid = 1'b0; root_base = root;
    end
    for (int i = 0; i < 400 && !done_valid; i++) @(negedge clk);
    r_done = done_valid; r_fault = done_fault; r_level = done_level;
    r_refill = refill_valid; r_paddr = done_paddr; r_vpn = refill_vpn;
    r_ppn = refill_ppn; r_perm = refill_perm;
    @(negedge clk);
    a_busy = busy; a_done = done_valid;
  endtask

  task automatic expect_success(input string tag, input logic [31:0] va,
                                input logic [31:0] root, input logic [31:0] pte1,
                                input logic [31:0] pte2, input int base);
    chk(tag, "request count", 32'(req_cnt - base), 32'd2);
    chk("R3", "first read address", req_log[base % 16], exp_l1(va, root));
    chk("R4", "second read address", req_log[(base + 1) % 16], exp_l2(pte1, va));
    chk("R9", "result strobe", {31'd0, r_done}, 32'd1);
    chk("R9", "fault flag", {31'd0, r_fault}, 32'd0);
    chk("R9", "refill valid", {31'd0, r_refill}, 32'd1);
    chk("R9", "physical address", r_paddr, {pte2[31:12], va[11:0]});
    chk("R9", "refill vpn", {12'd0, r_vpn}, {12'd0, va[31:12]});
    chk("R9", "refill ppn", {12'd0, r_ppn}, {12'd0, pte2[31:12]});
    chk("R9", "refill perm", {28'd0, r_perm}, {28'd0, pte2[4:1]});
    chk("R10", "strobe gone next cycle", {31'd0, a_done}, 32'd0);
    chk("R2", "idle after result", {31'd0, a_busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
    chk("R1", "request in reset", {31'd0, mem_req_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R1", "request after reset", {31'd0, mem_req_valid}, 32'd0);
    chk("R1", "strobe after reset", {31'd0, done_valid}, 32'd0);
    chk("R1", "refill after reset", {31'd0, refill_valid}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] va = 32'h1234_5678, root = 32'h0001_0000;
    logic [31:0] p1 = 32'h0002_0001, p2 = 32'hABCD_E017;
    int base = req_cnt;
    rsp_lat = 0;
    map_pages(va, root, p1, p2);
    run_walk(va, root, 1'b0);
    expect_success("R9", va, root, p1, p2, base);
  endtask

  task automatic t_corners();
    logic [31:0] root = 32'h0040_0000;
    logic [31:0] p1 = 32'h0007_F00F, p2 = 32'hFFFF_F01F;
    int base;
    // all-ones indices and offset, slow memory and stalls
    base = req_cnt; rsp_lat = 3; stall_n = 3; hold_viol = 0; overlap = 0;
    map_pages(32'hFFFF_FFFF, root, p1, p2);
    run_walk(32'hFFFF_FFFF, root, 1'b0);
    expect_success("R5", 32'hFFFF_FFFF, root, p1, p2, base);
    chk("R5", "request held while stalled", 32'(hold_viol), 32'd0);
    chk("R6", "overlapping requests", 32'(overlap), 32'd0);
    // all-zeros indices
    base = req_cnt; rsp_lat = 1; stall_n = 2;
    p1 = 32'h0000_3001; p2 = 32'h0000_5003;
    map_pages(32'h0000_0ABC, 32'h0, p1, p2);
    run_walk(32'h0000_0ABC, 32'h0, 1'b0);
    expect_success("R4", 32'h0000_0ABC, 32'h0, p1, p2, base);
    chk("R6", "overlapping requests (zero index)", 32'(overlap), 32'd0);
    chk("R5", "request held (zero index)", 32'(hold_viol), 32'd0);
    rsp_lat = 0;
  endtask

  task automatic t_root_fault();
    logic [31:0] va = 32'h8040_2123, root = 32'h0001_0000;
    int base = req_cnt;
    map_pages(va, root, 32'h0003_001E, 32'h0);
    run_walk(va, root, 1'b0);
    chk("R7", "single read", 32'(req_cnt - base), 32'd1);
    chk("R7", "read address", req_log[base % 16], exp_l1(va, root));
    chk("R7", "fault flag", {31'd0, r_fault}, 32'd1);
    chk("R7", "fault level", {31'd0, r_level}, 32'd0);
    chk("R7", "no refill", {31'd0, r_refill}, 32'd0);
    chk("R10", "strobe one cycle", {31'd0, a_done}, 32'd0);
  endtask

  task automatic t_leaf_fault();
    logic [31:0] va = 32'h0C03_F456, root = 32'h0002_0000;
    logic [31:0] p1 = 32'h0009_1001;
    int base = req_cnt;
    map_pages(va, root, p1, 32'hABCD_E016);
    run_walk(va, root, 1'b0);
    chk("R8", "two reads", 32'(req_cnt - base), 32'd2);
    chk("R8", "second address", req_log[(base + 1) % 16], exp_l2(p1, va));
    chk("R8", "fault flag", {31'd0, r_fault}, 32'd1);
    chk("R8", "fault level", {31'd0, r_level}, 32'd1);
    chk("R8", "no refill", {31'd0, r_refill}, 32'd0);
  endtask

  task automatic t_ignore_busy();
    logic [31:0] va = 32'h4567_89AB, root = 32'h0005_0000;
    logic [31:0] p1 = 32'h0006_1001, p2 = 32'h1357_9005;
    int base = req_cnt;
    rsp_lat = 4;
    map_pages(va, root, p1, p2);
    run_walk(va, root, 1'b1);
    expect_success("R2", va, root, p1, p2, base);
    repeat (4) @(negedge clk);
    chk("R2", "no walk from held-off miss", 32'(req_cnt - base), 32'd2);
    chk("R2", "stays idle", {31'd0, busy}, 32'd0);
    rsp_lat = 0;
  endtask

  task automatic t_stray();
    logic [31:0] va = 32'h2468_ACE0, root = 32'h0003_0000;
    logic [31:0] p1 = 32'h0004_4001, p2 = 32'h0BAD_0013;
    int base = req_cnt, d0 = done_cnt;
    @(negedge clk);
    stray_n = 3;
    repeat (5) @(negedge clk);
    chk("R11", "no strobe from stray response", 32'(done_cnt - d0), 32'd0);
    chk("R11", "no walk from stray response", {31'd0, busy}, 32'd0);
    chk("R11", "no request from stray response", 32'(req_cnt - base), 32'd0);
    map_pages(va, root, p1, p2);
    run_walk(va, root, 1'b0);
    expect_success("R11", va, root, p1, p2, base);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_corners();
    t_root_fault();
    t_leaf_fault();
    t_ignore_busy();
    t_stray();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule